// File: doc/BRIEF.md
# System Address Map Router

The router takes a 40-bit physical address and an access type, then decides which node and link of a multi-node system should receive the request. Three banks of programmable ranges are searched in parallel: memory ranges that map coarse 16 MB regions to nodes, memory-mapped I/O windows that map 64 KB regions to a node and link, and port I/O windows that map 4 KB regions of the I/O space to a node and link. Every range has its own read and write enable. Memory ranges can split a region across nodes by matching low address bits. Port I/O windows can claim the legacy display adapter ports and can refuse the aliased ISA ports.

Software programs the ranges through a simple one-cycle register-write port. A lookup is presented with `req_valid`. With the default `OUT_REG = 1` the result appears on the response outputs on the next clock edge. A result carries either a hit with its destination or a miss with an all-zero destination.

Top module: `sys_addr_router`

## Requirements
- R1: After reset every range is disabled, so any lookup misses, and `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_node`, `rsp_link` and `rsp_nonposted` are all 0.
- R2: With `OUT_REG = 1` the response to a lookup presented with `req_valid` appears one clock edge later with `rsp_valid` = 1. After a cycle without a request, `rsp_valid`, `rsp_hit` and `rsp_miss` are 0.
- R3: A memory request (`req_io` = 0) hits memory range i when address bits 39:24 lie in [base, limit], both bounds inclusive. It returns the range's node and link 0.
- R4: A range matches a read only when its read enable is set, and a write only when its write enable is set. This applies to all three banks.
- R5: The 3-bit interleave-enable code of a memory range picks the address bits that are compared: 001 selects A[12], 011 selects A[12] and A[14], 111 selects A[14:12], and every other code (000 included) selects none.
- R6: A memory range hits only if the selected bits among A[14:12] equal the matching bits of its 3-bit interleave select. Unselected bits are ignored.
- R7: A memory request hits memory-mapped I/O window i when A[39:16] lies in [base, limit]. It returns the window's node and link. A window hit takes priority over any memory-range hit.
- R8: `rsp_nonposted` is 1 only for a write that hits a memory-mapped I/O window whose non-posted bit is set. A read of the same window returns 0.
- R9: An I/O request (`req_io` = 1) is matched only against port I/O windows, and a memory request only against memory ranges and memory-mapped I/O windows. A port I/O window compares A[24:12] with [base, limit].
- R10: A port I/O window with its VGA enable set matches an address below 64K whose bits [9:0] lie in 0x3B0–0x3BB or 0x3C0–0x3DF, whatever its base and limit.
- R11: A port I/O window with its ISA enable set refuses the base/limit match for an address below 64K whose bits [9:8] are not 00, that is the top 768 bytes of each 1K block. The VGA match of R10 is not refused.
- R12: Within a bank, when several ranges match, the lowest-numbered range wins.
- R13: When nothing matches a valid lookup, `rsp_miss` = 1, `rsp_hit` = 0 and node, link and non-posted are 0.
- R14: A register write with `cfg_we` = 1 takes effect for lookups from the next cycle. `cfg_addr[5:4]` selects the bank (0 memory, 1 memory-mapped I/O, 2 port I/O, 3 none), `cfg_addr[3:1]` selects the range and `cfg_addr[0]` selects the word. The field layout is:
  - Memory word 0: bit 0 read enable, bit 1 write enable, [4:2] interleave enable, [7:5] interleave select, [31:16] base.
  - Memory word 1: [2:0] node, [31:16] limit.
  - Memory-mapped I/O word 0: bit 0 read enable, bit 1 write enable, [31:8] base.
  - Memory-mapped I/O word 1: [2:0] node, [5:4] link, bit 6 non-posted, [31:8] limit.
  - Port I/O word 0: bit 0 read enable, bit 1 write enable, bit 4 VGA enable, bit 5 ISA enable, [24:12] base.
  - Port I/O word 1: [2:0] node, [5:4] link, [24:12] limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Bank, range index and word select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request present |
| req_io | input | 1 | 1 = port I/O access, 0 = memory access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 40 | Physical or I/O address |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | A range matched |
| rsp_miss | output | 1 | No range matched |
| rsp_node | output | 3 | Destination node |
| rsp_link | output | 2 | Destination link |
| rsp_nonposted | output | 1 | Write must be non-posted |

## Verification
The bench builds the router with 8 memory ranges, 4 memory-mapped I/O windows and 4 port I/O windows, with the output register enabled. Eight memory ranges let it program all four interleave codes side by side in overlapping regions, and still keep a lower-numbered and a higher-numbered range over the same addresses for the priority check. Four port I/O windows are enough to give the VGA claim, the ISA refusal and a read-only catch-all their own window. That allows each address to be traced to exactly one winning window.

// File: rtl/amr_pkg.sv
package amr_pkg;
   localparam int PA_W     = 40;
   localparam int NODE_W   = 3;
   localparam int LINK_W   = 2;
   localparam int CFG_AW   = 6;
   localparam int CFG_DW   = 32;
   localparam int DRAM_LSB = 24;
   localparam int MMIO_LSB = 16;
   localparam int PIO_LSB  = 12;
   localparam int PIO_MSB  = 24;
   localparam int DRAM_SW  = PA_W - DRAM_LSB;
   localparam int MMIO_SW  = PA_W - MMIO_LSB;
   localparam int PIO_SW   = PIO_MSB - PIO_LSB + 1;

   typedef enum logic [1:0] {
      SP_DRAM = 2'd0,
      SP_MMIO = 2'd1,
      SP_PIO  = 2'd2,
      SP_NONE = 2'd3
   } space_e;

   typedef struct packed {
      logic              np;
      logic [LINK_W-1:0] link;
      logic [NODE_W-1:0] node;
   } route_t;

   // interleave-enable code to the mask of participating bits of A[14:12]
   function automatic logic [2:0] ilv_mask(input logic [2:0] code);
      case (code)
         3'b001:  return 3'b001;
         3'b011:  return 3'b101;
         3'b111:  return 3'b111;
         default: return 3'b000;
      endcase
   endfunction
endpackage

// File: rtl/amr_pick.sv
module amr_pick #(
   parameter int N = 8,
   parameter int W = 6
) (
   input  logic [N-1:0]        hit_vec,
   input  logic [N-1:0][W-1:0] pay_vec,
   output logic                any_hit,
   output logic [W-1:0]        pay_out
);
   // lowest index wins: scan downward so the last assignment is the lowest hit
   always_comb begin
      any_hit = 1'b0;
      pay_out = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (hit_vec[k]) begin
            any_hit = 1'b1;
            pay_out = pay_vec[k];
         end
      end
   end
endmodule

// File: rtl/amr_dram_bank.sv
module amr_dram_bank
   import amr_pkg::*;
#(
   parameter int N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_idx,
   input  logic              cfg_word,
   input  logic [CFG_DW-1:0] cfg_data,
   input  logic              lk_en,
   input  logic              lk_write,
   input  logic [PA_W-1:0]   lk_addr,
   output logic              bank_hit,
   output route_t            bank_rt
);
   localparam int RT_W = $bits(route_t);

   logic [DRAM_SW-1:0]        seg;
   logic [2:0]                ilv_bits;
   logic [N-1:0]              hit_vec;
   logic [N-1:0][RT_W-1:0]    pay_vec;
   logic [RT_W-1:0]           pick_pay;

   assign seg      = lk_addr[PA_W-1:DRAM_LSB];
   assign ilv_bits = lk_addr[14:12];

   for (genvar r = 0; r < N; r++) begin : g_rng
      logic               rd_ok, wr_ok;
      logic [2:0]         ien, isel, msk;
      logic [DRAM_SW-1:0] lo, hi;
      logic [NODE_W-1:0]  nd;
      logic               acc_ok, span_ok, ilv_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_ok <= 1'b0;
            wr_ok <= 1'b0;
            ien   <= '0;
            isel  <= '0;
            lo    <= '0;
            hi    <= '0;
            nd    <= '0;
         end else if (cfg_wr && cfg_idx == 3'(r)) begin
            if (!cfg_word) begin
               rd_ok <= cfg_data[0];
               wr_ok <= cfg_data[1];
               ien   <= cfg_data[4:2];
               isel  <= cfg_data[7:5];
               lo    <= cfg_data[31:16];
            end else begin
               nd    <= cfg_data[NODE_W-1:0];
               hi    <= cfg_data[31:16];
            end
         end
      end

      assign msk     = ilv_mask(ien);
      assign acc_ok  = lk_write ? wr_ok : rd_ok;
      assign span_ok = (seg >= lo) && (seg <= hi);
      assign ilv_ok  = (ilv_bits & msk) == (isel & msk);
      assign hit_vec[r] = lk_en && acc_ok && span_ok && ilv_ok;
      assign pay_vec[r] = route_t'{np: 1'b0, link: '0, node: nd};
   end

   amr_pick #(.N(N), .W(RT_W)) i_pick (
      .hit_vec (hit_vec),
      .pay_vec (pay_vec),
      .any_hit (bank_hit),
      .pay_out (pick_pay)
   );
   assign bank_rt = route_t'(pick_pay);
endmodule

// File: rtl/amr_mmio_bank.sv
module amr_mmio_bank
   import amr_pkg::*;
#(
   parameter int N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_idx,
   input  logic              cfg_word,
   input  logic [CFG_DW-1:0] cfg_data,
   input  logic              lk_en,
   input  logic              lk_write,
   input  logic [PA_W-1:0]   lk_addr,
   output logic              bank_hit,
   output route_t            bank_rt
);
   localparam int RT_W = $bits(route_t);

   logic [MMIO_SW-1:0]     seg;
   logic [N-1:0]           hit_vec;
   logic [N-1:0][RT_W-1:0] pay_vec;
   logic [RT_W-1:0]        pick_pay;

   assign seg = lk_addr[PA_W-1:MMIO_LSB];

   for (genvar r = 0; r < N; r++) begin : g_rng
      logic               rd_ok, wr_ok, np_bit;
      logic [MMIO_SW-1:0] lo, hi;
      logic [NODE_W-1:0]  nd;
      logic [LINK_W-1:0]  lk;
      logic               acc_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_ok  <= 1'b0;
            wr_ok  <= 1'b0;
            np_bit <= 1'b0;
            lo     <= '0;
            hi     <= '0;
            nd     <= '0;
            lk     <= '0;
         end else if (cfg_wr && cfg_idx == 3'(r)) begin
            if (!cfg_word) begin
               rd_ok  <= cfg_data[0];
               wr_ok  <= cfg_data[1];
               lo     <= cfg_data[31:8];
            end else begin
               nd     <= cfg_data[NODE_W-1:0];
               lk     <= cfg_data[5:4];
               np_bit <= cfg_data[6];
               hi     <= cfg_data[31:8];
            end
         end
      end

      assign acc_ok     = lk_write ? wr_ok : rd_ok;
      assign hit_vec[r] = lk_en && acc_ok && (seg >= lo) && (seg <= hi);
      assign pay_vec[r] = route_t'{np: np_bit && lk_write, link: lk, node: nd};
   end

   amr_pick #(.N(N), .W(RT_W)) i_pick (
      .hit_vec (hit_vec),
      .pay_vec (pay_vec),
      .any_hit (bank_hit),
      .pay_out (pick_pay)
   );
   assign bank_rt = route_t'(pick_pay);
endmodule

// File: rtl/amr_pio_bank.sv
module amr_pio_bank
   import amr_pkg::*;
#(
   parameter int N = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_idx,
   input  logic              cfg_word,
   input  logic [CFG_DW-1:0] cfg_data,
   input  logic              lk_en,
   input  logic              lk_write,
   input  logic [PA_W-1:0]   lk_addr,
   output logic              bank_hit,
   output route_t            bank_rt
);
   localparam int RT_W = $bits(route_t);

   logic [PIO_SW-1:0]      seg;
   logic                   low64k;
   logic [9:0]             lo10;
   logic                   vga_win, isa_alias;
   logic [N-1:0]           hit_vec;
   logic [N-1:0][RT_W-1:0] pay_vec;
   logic [RT_W-1:0]        pick_pay;

   assign seg       = lk_addr[PIO_MSB:PIO_LSB];
   assign low64k    = (lk_addr[PA_W-1:16] == '0);
   assign lo10      = lk_addr[9:0];
   assign vga_win   = low64k && (((lo10 >= 10'h3B0) && (lo10 <= 10'h3BB)) ||
                                 ((lo10 >= 10'h3C0) && (lo10 <= 10'h3DF)));
   assign isa_alias = low64k && (lo10[9:8] != 2'b00);

   for (genvar r = 0; r < N; r++) begin : g_rng
      logic              rd_ok, wr_ok, vga_en, isa_en;
      logic [PIO_SW-1:0] lo, hi;
      logic [NODE_W-1:0] nd;
      logic [LINK_W-1:0] lk;
      logic              acc_ok, span_ok, blocked;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_ok  <= 1'b0;
            wr_ok  <= 1'b0;
            vga_en <= 1'b0;
            isa_en <= 1'b0;
            lo     <= '0;
            hi     <= '0;
            nd     <= '0;
            lk     <= '0;
         end else if (cfg_wr && cfg_idx == 3'(r)) begin
            if (!cfg_word) begin
               rd_ok  <= cfg_data[0];
               wr_ok  <= cfg_data[1];
               vga_en <= cfg_data[4];
               isa_en <= cfg_data[5];
               lo     <= cfg_data[PIO_MSB:PIO_LSB];
            end else begin
               nd     <= cfg_data[NODE_W-1:0];
               lk     <= cfg_data[5:4];
               hi     <= cfg_data[PIO_MSB:PIO_LSB];
            end
         end
      end

      assign acc_ok  = lk_write ? wr_ok : rd_ok;
      assign span_ok = (seg >= lo) && (seg <= hi);
      assign blocked = isa_en && isa_alias;
      assign hit_vec[r] = lk_en && acc_ok &&
                          ((vga_en && vga_win) || (span_ok && !blocked));
      assign pay_vec[r] = route_t'{np: 1'b0, link: lk, node: nd};
   end

   amr_pick #(.N(N), .W(RT_W)) i_pick (
      .hit_vec (hit_vec),
      .pay_vec (pay_vec),
      .any_hit (bank_hit),
      .pay_out (pick_pay)
   );
   assign bank_rt = route_t'(pick_pay);
endmodule

// File: rtl/sys_addr_router.sv
module sys_addr_router
   import amr_pkg::*;
#(
   parameter int N_DRAM  = 8,
   parameter int N_MMIO  = 4,
   parameter int N_PIO   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [5:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   input  logic        req_valid,
   input  logic        req_io,
   input  logic        req_write,
   input  logic [39:0] req_addr,
   output logic        rsp_valid,
   output logic        rsp_hit,
   output logic        rsp_miss,
   output logic [2:0]  rsp_node,
   output logic [1:0]  rsp_link,
   output logic        rsp_nonposted
);
   // elaboration-time parameter checks: range index is 3 bits wide
   if (N_DRAM < 1 || N_DRAM > 8) begin : g_bad_dram
      $error("N_DRAM must be 1..8");
   end
   if (N_MMIO < 1 || N_MMIO > 8) begin : g_bad_mmio
      $error("N_MMIO must be 1..8");
   end
   if (N_PIO < 1 || N_PIO > 8) begin : g_bad_pio
      $error("N_PIO must be 1..8");
   end

   space_e     cfg_space;
   logic [2:0] cfg_idx;
   logic       cfg_word;
   logic       mem_lk, io_lk;
   logic       dram_hit, mmio_hit, pio_hit, sel_hit;
   route_t     dram_rt, mmio_rt, pio_rt, sel_rt;

   assign cfg_space = space_e'(cfg_addr[5:4]);
   assign cfg_idx   = cfg_addr[3:1];
   assign cfg_word  = cfg_addr[0];
   assign mem_lk    = req_valid && !req_io;
   assign io_lk     = req_valid && req_io;

   amr_dram_bank #(.N(N_DRAM)) i_dram (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_we && cfg_space == SP_DRAM), .cfg_idx(cfg_idx),
      .cfg_word(cfg_word), .cfg_data(cfg_wdata),
      .lk_en(mem_lk), .lk_write(req_write), .lk_addr(req_addr),
      .bank_hit(dram_hit), .bank_rt(dram_rt)
   );

   amr_mmio_bank #(.N(N_MMIO)) i_mmio (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_we && cfg_space == SP_MMIO), .cfg_idx(cfg_idx),
      .cfg_word(cfg_word), .cfg_data(cfg_wdata),
      .lk_en(mem_lk), .lk_write(req_write), .lk_addr(req_addr),
      .bank_hit(mmio_hit), .bank_rt(mmio_rt)
   );

   amr_pio_bank #(.N(N_PIO)) i_pio (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_we && cfg_space == SP_PIO), .cfg_idx(cfg_idx),
      .cfg_word(cfg_word), .cfg_data(cfg_wdata),
      .lk_en(io_lk), .lk_write(req_write), .lk_addr(req_addr),
      .bank_hit(pio_hit), .bank_rt(pio_rt)
   );

   // bank merge: I/O space alone for I/O, windows ahead of memory ranges
   always_comb begin
      sel_hit = 1'b0;
      sel_rt  = '0;
      if (io_lk) begin
         sel_hit = pio_hit;
         sel_rt  = pio_rt;
      end else if (mmio_hit) begin
         sel_hit = 1'b1;
         sel_rt  = mmio_rt;
      end else if (dram_hit) begin
         sel_hit = 1'b1;
         sel_rt  = dram_rt;
      end
   end

   logic   out_valid, out_hit, out_miss;
   route_t out_rt;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_miss  <= 1'b0;
            out_rt    <= '0;
         end else begin
            out_valid <= req_valid;
            out_hit   <= sel_hit;
            out_miss  <= req_valid && !sel_hit;
            out_rt    <= sel_rt;
         end
      end

      // R2
      rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);
      // R2
      rsp_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));
      // R8
      np_only_mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_nonposted |-> (rsp_hit && $past(req_write) && !$past(req_io)));
   end else begin : g_comb
      assign out_valid = req_valid;
      assign out_hit   = sel_hit;
      assign out_miss  = req_valid && !sel_hit;
      assign out_rt    = sel_rt;
   end

   assign rsp_valid     = out_valid;
   assign rsp_hit       = out_hit;
   assign rsp_miss      = out_miss;
   assign rsp_node      = out_rt.node;
   assign rsp_link      = out_rt.link;
   assign rsp_nonposted = out_rt.np;

   // R13
   hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rsp_miss));
   // R13
   miss_no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_node == '0 && rsp_link == '0 && !rsp_nonposted));
endmodule

// File: tb/test_sys_addr_router.sv
`timescale 1ns/1ps
module test_sys_addr_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_io = 1'b0;
   logic        req_write = 1'b0;
   logic [39:0] req_addr = '0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_nonposted;
   logic [2:0]  rsp_node;
   logic [1:0]  rsp_link;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sys_addr_router #(.N_DRAM(8), .N_MMIO(4), .N_PIO(4), .OUT_REG(1'b1)) i_sys_addr_router (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_io(req_io),
      .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_node(rsp_node),
      .rsp_link(rsp_link), .rsp_nonposted(rsp_nonposted)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic        io;
      logic        wr;
      logic [39:0] addr;
      logic        hit;
      logic [2:0]  node;
      logic [1:0]  link;
      logic        np;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VEC [NV] = '{
      '{4'd12, 1'b0, 1'b0, 40'h0000000000, 1'b1, 3'd1, 2'd0, 1'b0}, // R12 range 0 over 7
      '{4'd3,  1'b0, 1'b0, 40'h003FFFFFFF, 1'b1, 3'd1, 2'd0, 1'b0}, // R3 limit edge
      '{4'd3,  1'b0, 1'b0, 40'h0040000000, 1'b1, 3'd2, 2'd0, 1'b0}, // R3 base edge
      '{4'd4,  1'b0, 1'b1, 40'h0050000000, 1'b0, 3'd0, 2'd0, 1'b0}, // R4 read-only range
      '{4'd3,  1'b0, 1'b0, 40'h0350000000, 1'b1, 3'd7, 2'd0, 1'b0}, // R3
      '{4'd13, 1'b0, 1'b0, 40'h0200000000, 1'b0, 3'd0, 2'd0, 1'b0}, // R13 hole
      '{4'd5,  1'b0, 1'b0, 40'h0090001000, 1'b1, 3'd3, 2'd0, 1'b0}, // R5 A12=1
      '{4'd6,  1'b0, 1'b1, 40'h0090000000, 1'b1, 3'd4, 2'd0, 1'b0}, // R6 A12=0
      '{4'd5,  1'b0, 1'b0, 40'h0150005000, 1'b1, 3'd5, 2'd0, 1'b0}, // R5 101
      '{4'd6,  1'b0, 1'b0, 40'h0150007000, 1'b1, 3'd5, 2'd0, 1'b0}, // R6 A13 ignored
      '{4'd6,  1'b0, 1'b0, 40'h0150002000, 1'b1, 3'd6, 2'd0, 1'b0}, // R6 3-bit
      '{4'd6,  1'b0, 1'b0, 40'h0150000000, 1'b0, 3'd0, 2'd0, 1'b0}, // R6 none
      '{4'd6,  1'b0, 1'b0, 40'h0150004000, 1'b0, 3'd0, 2'd0, 1'b0}, // R6 none
      '{4'd7,  1'b0, 1'b0, 40'h0000150000, 1'b1, 3'd5, 2'd2, 1'b0}, // R7 over memory
      '{4'd8,  1'b0, 1'b1, 40'h0000150000, 1'b1, 3'd5, 2'd2, 1'b1}, // R8 non-posted
      '{4'd8,  1'b0, 1'b1, 40'h0000250000, 1'b1, 3'd3, 2'd3, 1'b0}, // R8 posted
      '{4'd7,  1'b0, 1'b0, 40'h00001FFFFF, 1'b1, 3'd5, 2'd2, 1'b0}, // R7 limit edge
      '{4'd7,  1'b0, 1'b0, 40'h0000200000, 1'b1, 3'd3, 2'd3, 1'b0}, // R7 base edge
      '{4'd4,  1'b0, 1'b1, 40'h0001500000, 1'b1, 3'd1, 2'd0, 1'b0}, // R4 falls to memory
      '{4'd7,  1'b0, 1'b0, 40'h0001500000, 1'b1, 3'd6, 2'd1, 1'b0}, // R7
      '{4'd9,  1'b0, 1'b1, 40'h00000003C5, 1'b1, 3'd1, 2'd0, 1'b0}, // R9 no VGA on memory
      '{4'd9,  1'b1, 1'b0, 40'h0000012345, 1'b1, 3'd2, 2'd1, 1'b0}, // R9
      '{4'd4,  1'b1, 1'b1, 40'h0000012345, 1'b1, 3'd2, 2'd1, 1'b0}, // R4
      '{4'd10, 1'b1, 1'b0, 40'h00000003C5, 1'b1, 3'd4, 2'd3, 1'b0}, // R10
      '{4'd10, 1'b1, 1'b1, 40'h00000007B3, 1'b1, 3'd4, 2'd3, 1'b0}, // R10 alias
      '{4'd10, 1'b1, 1'b1, 40'h00000203C0, 1'b0, 3'd0, 2'd0, 1'b0}, // R10 above 64K
      '{4'd11, 1'b1, 1'b0, 40'h00000003BC, 1'b1, 3'd1, 2'd0, 1'b0}, // R11 blocked
      '{4'd11, 1'b1, 1'b1, 40'h00000003BC, 1'b0, 3'd0, 2'd0, 1'b0}, // R11
      '{4'd11, 1'b1, 1'b1, 40'h0000000C50, 1'b1, 3'd6, 2'd2, 1'b0}, // R11 low 256
      '{4'd11, 1'b1, 1'b1, 40'h0000000D50, 1'b0, 3'd0, 2'd0, 1'b0}, // R11 alias
      '{4'd9,  1'b1, 1'b1, 40'h0050000000, 1'b1, 3'd6, 2'd2, 1'b0}  // R9 I/O only
   };

   function automatic logic [31:0] dram_w0(input logic [15:0] b, input logic [2:0] sel,
                                           input logic [2:0] ien, input logic we, input logic re);
      return {b, 8'h00, sel, ien, we, re};
   endfunction
   function automatic logic [31:0] dram_w1(input logic [15:0] l, input logic [2:0] n);
      return {l, 13'h0, n};
   endfunction
   function automatic logic [31:0] mmio_w0(input logic [23:0] b, input logic we, input logic re);
      return {b, 6'h0, we, re};
   endfunction
   function automatic logic [31:0] mmio_w1(input logic [23:0] l, input logic np,
                                           input logic [1:0] lk, input logic [2:0] n);
      return {l, 1'b0, np, lk, 1'b0, n};
   endfunction
   function automatic logic [31:0] pio_w0(input logic [12:0] b, input logic isa, input logic vga,
                                          input logic we, input logic re);
      return {7'h0, b, 6'h0, isa, vga, 2'b00, we, re};
   endfunction
   function automatic logic [31:0] pio_w1(input logic [12:0] l, input logic [1:0] lk,
                                          input logic [2:0] n);
      return {7'h0, l, 6'h0, lk, 1'b0, n};
   endfunction

   task automatic cfg(input logic [1:0] sp, input logic [2:0] idx, input logic wd,
                      input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {sp, idx, wd}; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic look(input int rq, input logic io, input logic wr, input logic [39:0] a,
                       input logic eh, input logic [2:0] en, input logic [1:0] el,
                       input logic enp);
      @(negedge clk);
      req_valid = 1'b1; req_io = io; req_write = wr; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      n_cmp++;
      if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_miss !== !eh || rsp_node !== en ||
          rsp_link !== el || rsp_nonposted !== enp) begin
         n_bad++;
         $display("FAIL R%0d addr=%h io=%b wr=%b got v=%b h=%b m=%b n=%0d l=%0d np=%b exp v=1 h=%b m=%b n=%0d l=%0d np=%b",
                  rq, a, io, wr, rsp_valid, rsp_hit, rsp_miss, rsp_node, rsp_link,
                  rsp_nonposted, eh, !eh, en, el, enp);
      end
   endtask

   task automatic chk_idle(input int rq);
      n_cmp++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0 || rsp_node !== 3'd0 ||
          rsp_link !== 2'd0 || rsp_nonposted !== 1'b0) begin
         n_bad++;
         $display("FAIL R%0d idle outputs got v=%b h=%b m=%b n=%0d l=%0d np=%b exp all 0",
                  rq, rsp_valid, rsp_hit, rsp_miss, rsp_node, rsp_link, rsp_nonposted);
      end
   endtask

   task automatic program_map();
      // memory ranges (R14 layout)
      cfg(2'd0, 3'd0, 1'b0, dram_w0(16'h0000, 3'd0, 3'b000, 1'b1, 1'b1));
      cfg(2'd0, 3'd0, 1'b1, dram_w1(16'h003F, 3'd1));
      cfg(2'd0, 3'd1, 1'b0, dram_w0(16'h0040, 3'd0, 3'b000, 1'b0, 1'b1));
      cfg(2'd0, 3'd1, 1'b1, dram_w1(16'h007F, 3'd2));
      cfg(2'd0, 3'd2, 1'b0, dram_w0(16'h0080, 3'b001, 3'b001, 1'b1, 1'b1));
      cfg(2'd0, 3'd2, 1'b1, dram_w1(16'h00FF, 3'd3));
      cfg(2'd0, 3'd3, 1'b0, dram_w0(16'h0080, 3'b000, 3'b001, 1'b1, 1'b1));
      cfg(2'd0, 3'd3, 1'b1, dram_w1(16'h00FF, 3'd4));
      cfg(2'd0, 3'd4, 1'b0, dram_w0(16'h0100, 3'b101, 3'b011, 1'b1, 1'b1));
      cfg(2'd0, 3'd4, 1'b1, dram_w1(16'h01FF, 3'd5));
      cfg(2'd0, 3'd5, 1'b0, dram_w0(16'h0100, 3'b010, 3'b111, 1'b1, 1'b1));
      cfg(2'd0, 3'd5, 1'b1, dram_w1(16'h01FF, 3'd6));
      cfg(2'd0, 3'd6, 1'b0, dram_w0(16'h0300, 3'd0, 3'b000, 1'b1, 1'b1));
      cfg(2'd0, 3'd6, 1'b1, dram_w1(16'h03FF, 3'd7));
      cfg(2'd0, 3'd7, 1'b0, dram_w0(16'h0000, 3'd0, 3'b000, 1'b1, 1'b1));
      cfg(2'd0, 3'd7, 1'b1, dram_w1(16'h0010, 3'd0));
      // memory-mapped I/O windows
      cfg(2'd1, 3'd0, 1'b0, mmio_w0(24'h000010, 1'b1, 1'b1));
      cfg(2'd1, 3'd0, 1'b1, mmio_w1(24'h00001F, 1'b1, 2'd2, 3'd5));
      cfg(2'd1, 3'd1, 1'b0, mmio_w0(24'h000100, 1'b0, 1'b1));
      cfg(2'd1, 3'd1, 1'b1, mmio_w1(24'h0001FF, 1'b0, 2'd1, 3'd6));
      cfg(2'd1, 3'd2, 1'b0, mmio_w0(24'h000020, 1'b1, 1'b1));
      cfg(2'd1, 3'd2, 1'b1, mmio_w1(24'h00002F, 1'b0, 2'd3, 3'd3));
      // port I/O windows
      cfg(2'd2, 3'd0, 1'b0, pio_w0(13'h0010, 1'b0, 1'b0, 1'b1, 1'b1));
      cfg(2'd2, 3'd0, 1'b1, pio_w1(13'h001F, 2'd1, 3'd2));
      cfg(2'd2, 3'd1, 1'b0, pio_w0(13'h1FFF, 1'b0, 1'b1, 1'b1, 1'b1));
      cfg(2'd2, 3'd1, 1'b1, pio_w1(13'h0000, 2'd3, 3'd4));
      cfg(2'd2, 3'd2, 1'b0, pio_w0(13'h0000, 1'b1, 1'b0, 1'b1, 1'b1));
      cfg(2'd2, 3'd2, 1'b1, pio_w1(13'h000F, 2'd2, 3'd6));
      cfg(2'd2, 3'd3, 1'b0, pio_w0(13'h0000, 1'b0, 1'b0, 1'b0, 1'b1));
      cfg(2'd2, 3'd3, 1'b1, pio_w1(13'h1FFF, 2'd0, 3'd1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs at reset
      chk_idle(1);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: nothing programmed, every lookup misses
      look(1, 1'b0, 1'b0, 40'h0000000000, 1'b0, 3'd0, 2'd0, 1'b0);
      look(1, 1'b1, 1'b0, 40'h00000003C5, 1'b0, 3'd0, 2'd0, 1'b0);
      program_map();
      for (int k = 0; k < NV; k++)
         look(int'(VEC[k].rq), VEC[k].io, VEC[k].wr, VEC[k].addr, VEC[k].hit,
              VEC[k].node, VEC[k].link, VEC[k].np);
      // R2: one idle cycle after a lookup leaves outputs quiet
      @(negedge clk);
      chk_idle(2);
      // R14 and R12: disable range 0, range 7 now owns address 0
      cfg(2'd0, 3'd0, 1'b0, dram_w0(16'h0000, 3'd0, 3'b000, 1'b0, 1'b0));
      look(14, 1'b0, 1'b0, 40'h0000000000, 1'b1, 3'd0, 2'd0, 1'b0);
      // R14: bank code 3 writes nothing
      cfg(2'd3, 3'd2, 1'b0, 32'h0);
      look(14, 1'b0, 1'b0, 40'h0090001000, 1'b1, 3'd3, 2'd0, 1'b0);
      // R1: reset clears the programmed map
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk_idle(1);
      rst_n = 1'b1;
      look(1, 1'b0, 1'b0, 40'h0090001000, 1'b0, 3'd0, 2'd0, 1'b0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired got running exp finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule